// File: doc/BRIEF.md
# Receive Packet Error Checker

This block watches a 16-bit receive word stream taken after framing on a packet-over-lanes interface. Every cycle at most one word arrives, tagged either as a control word or as a payload word. The checker reads the control words, which carry packet start, packet end and abort marks. It tells the user side where packets begin and end, checks them for errors, and passes the payload on as beats that carry data, start, end, error, a byte-valid flag and the channel address.

Each payload word is held for one cycle, so that an end mark arriving in the following control word can be attached to it. The block raises one-cycle error pulses in three cases: two packet starts closer together than the minimum spacing, a nonzero padding byte at the end of an odd-length packet, and an aborted packet. In the last two cases it also marks the end beat as errored and forces that beat to an even byte count. After a reserved control word it discards payload until a fresh packet start arrives.

Top module: `rx_err_check`

## Requirements
- R1: A word with `in_ctl` high is a control word. Its fields are: bit 12 packet start; bits 11:4 channel; bits 14:13 end code (00 no end, 01 abort, 10 end with both bytes valid, 11 end with only the upper byte valid). Bits 3:0 and bit 15 do not change the behaviour.
- R2: A payload word is held until the next payload word or end-coded control word releases it. It then appears on the outputs one cycle after the releasing word, with `out_eop` high when the release was an end code. `out_mty` high means only bits 15:8 are valid.
- R3: A start that comes fewer than SPACE_MIN (8) cycles after the previous start pulses `err_space` for one cycle, one cycle after the start. The data is left untouched. A spacing of exactly 8 does not pulse, and neither does the first start after reset.
- R4: An end code 11 whose held word has a nonzero low byte gives an end beat with `out_err` high and `out_mty` low, and pulses `err_pad` in the same cycle as that beat.
- R5: An end code 01 pulses `err_abort` one cycle later. Any held word is delivered as an end beat with `out_err` high and `out_mty` low.
- R6: A control word with end code 00, start clear and a nonzero channel is reserved. Payload that follows it is discarded until the next control word with the start bit set.
- R7: An idle control word (bits 14:4 all zero) produces no beat and leaves the held word and the packet state as they were.
- R8: The first payload word after a start control word is delivered with `out_sop` high. Every beat carries the channel of the most recent start in `out_chan`.
- R9: While `rst_n` is low, `out_valid` and all three error pulses are low, and the spacing tracker is treated as having seen no start.
- R10: `out_err` is high only on an end beat, and such a beat always reports both bytes valid (`out_mty` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| in_ctl | input | 1 | Input word is a control word |
| in_word | input | 16 | Input word |
| out_valid | output | 1 | Output beat present |
| out_data | output | 16 | Beat payload |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_err | output | 1 | Packet is errored (end beat only) |
| out_mty | output | 1 | Only the upper byte of the end beat is valid |
| out_chan | output | 8 | Channel of the current packet |
| err_space | output | 1 | Start spacing violation pulse |
| err_pad | output | 1 | Nonzero pad byte pulse |
| err_abort | output | 1 | Abort received pulse |

## Verification
The bench places starts exactly 7 and exactly 8 cycles apart. An off-by-one spacing counter would flag both or neither, and a counter that resets to zero would flag the very first start. End codes 11 are sent with a zero pad byte and with a nonzero pad byte. A design that errors every odd packet, or one that leaves the byte-valid flag at one byte on an errored packet, shows a wrong beat. Payload sent after a reserved word, including payload after an end code that arrives while discarding, must never come out. Idle words in the middle of a packet and back-to-back packets, where one control word both ends a packet and starts the next, expose a design that releases the held word too early or loses the start mark.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;

  localparam int WORD_W = 16;
  localparam int CHAN_W = 8;

  typedef enum logic [1:0] {
    END_NONE  = 2'b00,
    END_ABORT = 2'b01,
    END_TWO   = 2'b10,
    END_ONE   = 2'b11
  } end_code_e;

  typedef struct packed {
    logic               is_pay;
    logic               is_idle;
    logic               is_rsvd;
    logic               is_sop;
    end_code_e          endc;
    logic [CHAN_W-1:0]  chan;
    logic [WORD_W-1:0]  data;
  } rx_dec_t;

endpackage

// File: rtl/rxchk_decode.sv
module rxchk_decode
  import rxchk_pkg::*;
(
  input  logic              in_valid,
  input  logic              in_ctl,
  input  logic [WORD_W-1:0] in_word,
  output rx_dec_t           dec
);

  logic ctl_v;

  always_comb begin
    ctl_v        = in_valid && in_ctl;
    dec.data     = in_word;
    dec.chan     = in_word[11:4];
    dec.is_pay   = in_valid && !in_ctl;
    dec.is_sop   = ctl_v && in_word[12];
    dec.endc     = ctl_v ? end_code_e'(in_word[14:13]) : END_NONE;
    dec.is_idle  = ctl_v && (in_word[14:4] == 11'd0);
    dec.is_rsvd  = ctl_v && (in_word[14:13] == 2'b00) && !in_word[12] &&
                   (in_word[11:4] != '0);
  end

endmodule

// File: rtl/rxchk_space.sv
module rxchk_space #(
  parameter int SPACE_MIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic err_space
);

  localparam int CNT_W = $clog2(SPACE_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SPACE_MIN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;

  always_comb begin
    cnt_d = cnt_q;
    err_d = 1'b0;
    if (start) begin
      err_d = (cnt_q < CNT_SAT);
      cnt_d = CNT_W'(1);
    end else if (cnt_q < CNT_SAT) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_SAT;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign err_space = err_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT); // R3

  AST_SPACE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    err_space |-> $past(start)); // R3

endmodule

// File: rtl/rxchk_beat.sv
module rxchk_beat
  import rxchk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rx_dec_t           dec,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_err,
  output logic              out_mty,
  output logic [CHAN_W-1:0] out_chan,
  output logic              err_pad,
  output logic              err_abort
);

  // holding stage
  logic              hv_q, hv_d;
  logic [WORD_W-1:0] hd_q, hd_d;
  logic              hs_q, hs_d;
  logic [CHAN_W-1:0] hc_q, hc_d;
  // packet state
  logic              pend_q, pend_d;
  logic [CHAN_W-1:0] pch_q, pch_d;
  logic              drop_q, drop_d;
  // output stage
  logic              ov_q, ov_d;
  logic [WORD_W-1:0] od_q, od_d;
  logic              os_q, os_d;
  logic              oe_q, oe_d;
  logic              oerr_q, oerr_d;
  logic              om_q, om_d;
  logic [CHAN_W-1:0] oc_q, oc_d;
  logic              pad_q, pad_d;
  logic              abt_q, abt_d;
  logic              hold_en, out_en;

  always_comb begin
    hv_d   = hv_q;
    hd_d   = hd_q;
    hs_d   = hs_q;
    hc_d   = hc_q;
    pend_d = pend_q;
    pch_d  = pch_q;
    drop_d = drop_q;
    ov_d   = 1'b0;
    od_d   = od_q;
    os_d   = 1'b0;
    oe_d   = 1'b0;
    oerr_d = 1'b0;
    om_d   = 1'b0;
    oc_d   = oc_q;
    pad_d  = 1'b0;
    abt_d  = 1'b0;
    hold_en = 1'b0;
    out_en  = 1'b0;

    if (dec.endc != END_NONE) begin
      abt_d = (dec.endc == END_ABORT);
      if (hv_q) begin
        out_en = 1'b1;
        ov_d   = 1'b1;
        od_d   = hd_q;
        os_d   = hs_q;
        oc_d   = hc_q;
        oe_d   = 1'b1;
        hv_d   = 1'b0;
        unique case (dec.endc)
          END_ABORT: oerr_d = 1'b1;
          END_ONE: begin
            if (hd_q[7:0] != 8'h00) begin
              oerr_d = 1'b1;
              pad_d  = 1'b1;
            end else begin
              om_d = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end

    if (dec.is_sop) begin
      pend_d = 1'b1;
      pch_d  = dec.chan;
      drop_d = 1'b0;
    end

    if (dec.is_rsvd) begin
      drop_d = 1'b1;
    end

    if (dec.is_pay && !drop_q) begin
      hold_en = 1'b1;
      if (hv_q) begin
        out_en = 1'b1;
        ov_d   = 1'b1;
        od_d   = hd_q;
        os_d   = hs_q;
        oc_d   = hc_q;
      end
      hv_d   = 1'b1;
      hd_d   = dec.data;
      hs_d   = pend_q;
      hc_d   = pch_q;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q   <= 1'b0;
      pend_q <= 1'b0;
      pch_q  <= '0;
      drop_q <= 1'b0;
      ov_q   <= 1'b0;
      os_q   <= 1'b0;
      oe_q   <= 1'b0;
      oerr_q <= 1'b0;
      om_q   <= 1'b0;
      pad_q  <= 1'b0;
      abt_q  <= 1'b0;
    end else begin
      hv_q   <= hv_d;
      pend_q <= pend_d;
      pch_q  <= pch_d;
      drop_q <= drop_d;
      ov_q   <= ov_d;
      os_q   <= os_d;
      oe_q   <= oe_d;
      oerr_q <= oerr_d;
      om_q   <= om_d;
      pad_q  <= pad_d;
      abt_q  <= abt_d;
    end
  end

  // data-path registers, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q <= '0;
      hs_q <= 1'b0;
      hc_q <= '0;
    end else if (hold_en) begin
      hd_q <= hd_d;
      hs_q <= hs_d;
      hc_q <= hc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q <= '0;
      oc_q <= '0;
    end else if (out_en) begin
      od_q <= od_d;
      oc_q <= oc_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_sop   = os_q;
  assign out_eop   = oe_q;
  assign out_err   = oerr_q;
  assign out_mty   = om_q;
  assign out_chan  = oc_q;
  assign err_pad   = pad_q;
  assign err_abort = abt_q;

  AST_ERR_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> out_eop); // R10

  AST_ERR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> !out_mty); // R10

  AST_PAD_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    err_pad |-> (out_valid && out_eop && out_err)); // R4

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q && dec.is_pay) |=> (!out_valid && $stable(hd_q))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dec.is_idle |=> (!out_valid && $stable(hv_q) && $stable(drop_q))); // R7

endmodule

// File: rtl/rx_err_check.sv
module rx_err_check
  import rxchk_pkg::*;
#(
  parameter int SPACE_MIN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_ctl,
  input  logic [15:0] in_word,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic        out_sop,
  output logic        out_eop,
  output logic        out_err,
  output logic        out_mty,
  output logic [7:0]  out_chan,
  output logic        err_space,
  output logic        err_pad,
  output logic        err_abort
);

  rx_dec_t dec;

  rxchk_decode i_decode (
    .in_valid (in_valid),
    .in_ctl   (in_ctl),
    .in_word  (in_word),
    .dec      (dec)
  );

  rxchk_space #(.SPACE_MIN(SPACE_MIN)) i_space (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (dec.is_sop),
    .err_space (err_space)
  );

  rxchk_beat i_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (dec),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_err   (out_err),
    .out_mty   (out_mty),
    .out_chan  (out_chan),
    .err_pad   (err_pad),
    .err_abort (err_abort)
  );

  AST_ABORT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    err_abort |-> $past(in_valid && in_ctl && (in_word[14:13] == 2'b01))); // R5

endmodule

// File: tb/test_rx_err_check.sv
module test_rx_err_check;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ctl;
  logic [15:0] in_word;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_sop;
  logic        out_eop;
  logic        out_err;
  logic        out_mty;
  logic [7:0]  out_chan;
  logic        err_space;
  logic        err_pad;
  logic        err_abort;

  rx_err_check i_rx_err_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ctl    (in_ctl),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_err   (out_err),
    .out_mty   (out_mty),
    .out_chan  (out_chan),
    .err_space (err_space),
    .err_pad   (err_pad),
    .err_abort (err_abort)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] data;
    logic        sop;
    logic        eop;
    logic        err;
    logic        mty;
    logic [7:0]  chan;
    string       tag;
  } beat_t;

  beat_t exp_q[$];

  int errors = 0;
  int checks = 0;
  bit mon_on = 0;
  bit done   = 0;

  // reference model state
  int          cyc = 0;
  int          last_sop = 0;
  bit          seen_sop = 0;
  bit          m_hv = 0;
  logic [15:0] m_hd = '0;
  bit          m_hs = 0;
  logic [7:0]  m_hc = '0;
  bit          m_pend = 0;
  logic [7:0]  m_pch = '0;
  bit          m_drop = 0;
  bit          x_space = 0;
  bit          x_pad = 0;
  bit          x_abort = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_beat(input bit eop, input bit err, input bit mty, input string tag);
    beat_t b;
    b.data = m_hd; b.sop = m_hs; b.eop = eop; b.err = err; b.mty = mty;
    b.chan = m_hc;
    b.tag  = m_hs ? "R8" : tag;
    exp_q.push_back(b);
  endtask

  // one input cycle; checks flags caused by the previous cycle
  task automatic drive(input bit v, input bit c, input logic [15:0] w);
    logic [1:0] e;
    @(negedge clk);
    chk(err_space == x_space, "R3", "err_space", err_space, x_space);
    chk(err_pad   == x_pad,   "R4", "err_pad",   err_pad,   x_pad);
    chk(err_abort == x_abort, "R5", "err_abort", err_abort, x_abort);
    in_valid = v; in_ctl = c; in_word = w;
    cyc++;
    x_space = 0; x_pad = 0; x_abort = 0;
    if (v && c) begin
      e = w[14:13];
      if (e == 2'b01) x_abort = 1;
      if (e != 2'b00 && m_hv) begin
        if (e == 2'b01)      push_beat(1, 1, 0, "R5");
        else if (e == 2'b10) push_beat(1, 0, 0, "R2");
        else if (m_hd[7:0] != 8'h00) begin
          push_beat(1, 1, 0, "R4");
          x_pad = 1;
        end else push_beat(1, 0, 1, "R2");
        m_hv = 0;
      end
      if (w[12]) begin
        if (seen_sop && (cyc - last_sop) < 8) x_space = 1;
        seen_sop = 1; last_sop = cyc;
        m_pend = 1; m_pch = w[11:4]; m_drop = 0;
      end
      if (e == 2'b00 && !w[12] && w[11:4] != 8'h00) m_drop = 1;
    end else if (v && !c && !m_drop) begin
      if (m_hv) push_beat(0, 0, 0, "R2");
      m_hv = 1; m_hd = w; m_hs = m_pend; m_hc = m_pch; m_pend = 0;
    end
  endtask

  // control word: bit15 set, end code, start, channel, arbitrary parity (R1)
  function automatic logic [15:0] cw(input logic [1:0] e, input bit s, input logic [7:0] ch);
    return {1'b1, e, s, ch, 4'hA};
  endfunction

  task automatic ctl(input logic [1:0] e, input bit s, input logic [7:0] ch);
    drive(1, 1, cw(e, s, ch));
  endtask
  task automatic pay(input logic [15:0] d); drive(1, 0, d); endtask
  task automatic idle(); drive(1, 1, 16'h8005); endtask
  task automatic gap(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 16'h0000);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2", "unexpected beat data", out_data, 0);
      end else begin
        beat_t b;
        b = exp_q.pop_front();
        chk(out_data == b.data, b.tag, "data", out_data, b.data);
        chk(out_sop  == b.sop,  "R8", "sop",  out_sop,  b.sop);
        chk(out_chan == b.chan, "R8", "chan", out_chan, b.chan);
        chk(out_eop  == b.eop,  b.tag, "eop",  out_eop,  b.eop);
        chk(out_err  == b.err,  b.tag, "err",  out_err,  b.err);
        chk(out_mty  == b.mty,  b.tag, "mty",  out_mty,  b.mty);
        if (out_err) chk(!out_mty, "R10", "errored beat not even", out_mty, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_ctl = 0; in_word = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid == 0, "R9", "out_valid in reset", out_valid, 0);
    chk({err_space, err_pad, err_abort} == 3'b000, "R9", "flags in reset",
        {err_space, err_pad, err_abort}, 0);
    @(posedge clk); #2 rst_n = 1;
    mon_on = 1;

    // R1 R2 R8: plain packet, two-byte end (first start: no spacing flag)
    ctl(2'b00, 1, 8'h05); pay(16'h1234); pay(16'h5678); pay(16'h9ABC);
    ctl(2'b10, 0, 8'h00); gap(8);
    // R2: odd packet, zero pad byte
    ctl(2'b00, 1, 8'h06); pay(16'h1111); pay(16'h2200); ctl(2'b11, 0, 8'h00); gap(8);
    // R4: odd packet, nonzero pad
    ctl(2'b00, 1, 8'h07); pay(16'h3333); pay(16'h445A); ctl(2'b11, 0, 8'h00); gap(8);
    // R5: abort
    ctl(2'b00, 1, 8'h08); pay(16'h5555); pay(16'h6666); ctl(2'b01, 0, 8'h00); gap(8);
    // R7: idle words inside a packet
    ctl(2'b00, 1, 8'h09); pay(16'h7777); idle(); pay(16'h8888); idle();
    ctl(2'b10, 0, 8'h00); gap(8);
    // R6: reserved word, payload dropped across an end code until next start
    ctl(2'b00, 1, 8'h03); pay(16'hAAAA); ctl(2'b00, 0, 8'h42);
    pay(16'hBBBB); pay(16'hCCCC); ctl(2'b10, 0, 8'h00); pay(16'hEEEE); gap(8);
    ctl(2'b00, 1, 8'h04); pay(16'hDDDD); ctl(2'b10, 0, 8'h00); gap(8);
    // R3: starts exactly 7 apart (flag) then exactly 8 apart (no flag)
    ctl(2'b00, 1, 8'h01); pay(16'h0101); ctl(2'b10, 0, 8'h00); gap(4);
    ctl(2'b00, 1, 8'h02); pay(16'h0202); ctl(2'b10, 0, 8'h00); gap(5);
    ctl(2'b00, 1, 8'h03); pay(16'h0303); ctl(2'b10, 0, 8'h00); gap(8);
    // back-to-back packets: end and start in one word, close spacing
    ctl(2'b00, 1, 8'h11); pay(16'h0A0A); ctl(2'b10, 1, 8'h12); pay(16'h0B0B);
    ctl(2'b11, 1, 8'h13); pay(16'h0C0C); ctl(2'b01, 0, 8'h00);
    gap(6);

    chk(exp_q.size() == 0, "R2", "beats missing", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule